// File: doc/BRIEF.md
# Coprocessor Context Save Sequencer

This block is the host-side engine that saves a coprocessor's context to memory. A one-cycle `start` begins the save, and the base address is captured at that moment. The engine then reads the 16-bit save-status word from the coprocessor. Bits 15:8 of that word carry a status code and bits 7:0 carry a frame size in bytes. The code decides what happens next. The engine may read the status word again, store only that word, store the word followed by a frame of longwords, or reject the word. When it finishes, it pulses `done`, together with an error or timeout flag where one applies.

Reads from the coprocessor use a request handshake. While `cp_rd_valid` is high, `cp_rd_sel` picks the register: 0 is the status word and 1 is the operand longword. The read completes in the cycle when `cp_rd_ready` is also high, and `cp_rd_data` is taken in that same cycle. Writes to memory use `mem_valid`/`mem_ready`. Under back-pressure, a raised valid stays high and its select, address and data stay frozen until the partner accepts. Either partner may stall for any number of cycles.

All outputs come from registers and none depends on an input in the same cycle. Every memory address is the captured base plus a byte offset that grows by four with each write.

Top module: `cp_save_seq`

## Requirements
- R1: After reset, `busy`, `done`, `format_error`, `timeout`, `cp_rd_valid` and `mem_valid` are all low.
- R2: A `start` seen while idle makes the sequencer busy and starts a status-word read (`cp_rd_sel`=0) in the next cycle. A `start` seen while busy is ignored.
- R3: Status code 0x01 (not ready) causes the status word to be read again. Nothing is written to memory while this repeats.
- R4: When RETRY_LIMIT consecutive 0x01 codes arrive in one save, the save ends with `timeout` and `done` high together for one cycle, and nothing is written.
- R5: Status code 0x00 (empty) causes one memory write to the base address, with data equal to the status word zero-extended from bits 15:0. `done` follows.
- R6: Codes 0x02 to 0x0F end the save with `format_error` and `done` high together for one cycle, and nothing is written.
- R7: Codes 0x10 to 0xFF with a size that is a multiple of four write the status word at the base address. They then read size/4 operand longwords (`cp_rd_sel`=1) and write them in order to base+4, base+8 and so on. A size of 0 writes only the status word.
- R8: A code of 0x10 or above whose size has bits 1:0 non-zero is a format error, handled as in R6.
- R9: A raised `mem_valid` or `cp_rd_valid` stays high until accepted. Address, data and select stay stable until then.
- R10: `done` is a one-cycle pulse in the first idle cycle after a save. `busy` is high from the cycle after the accepted `start` until that cycle.
- R11: A `start` in the cycle `done` is high is accepted, so saves can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a save (taken only when idle) |
| base_addr | input | AW | Destination byte address, captured at start |
| busy | output | 1 | A save is in progress |
| done | output | 1 | One-cycle completion pulse |
| format_error | output | 1 | Save rejected for a bad code or size (with done) |
| timeout | output | 1 | Retry limit reached (with done) |
| cp_rd_valid | output | 1 | Coprocessor read request |
| cp_rd_ready | input | 1 | Coprocessor accepts the read; data is valid |
| cp_rd_sel | output | 1 | 0 = status word, 1 = operand longword |
| cp_rd_data | input | DW | Read data; status word in bits 15:0 |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW | Write byte address |
| mem_wdata | output | DW | Write data |

## Verification
Two events can fall in one cycle. The first is the `done` pulse that closes one save. The second is the acceptance of a `start` that opens the next. To provoke this, the bench holds `start` high across the end of a save. It then expects the next status read to be requested in the very next cycle, with the `done` count and the write count matching the two saves. A second overlap comes from raising `start` in the middle of a save. The reference model predicts that this `start` has no effect, and the bench compares the outputs against it on every cycle. The write count for that save must also be unchanged.

// File: rtl/cp_save_pkg.sv
package cp_save_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FMT_RD,
    ST_FMT_WR,
    ST_OP_RD,
    ST_OP_WR
  } seq_state_e;

  typedef enum logic [1:0] {
    FK_EMPTY,
    FK_RETRY,
    FK_BAD,
    FK_FRAME
  } fmt_kind_e;

  localparam logic [7:0] CODE_EMPTY       = 8'h00;
  localparam logic [7:0] CODE_RETRY       = 8'h01;
  localparam logic [7:0] CODE_FIRST_VALID = 8'h10;
endpackage

// File: rtl/cp_save_fmt_decode.sv
module cp_save_fmt_decode
  import cp_save_pkg::*;
#(
  parameter int FW = 16,
  parameter int CW = 6
) (
  input  logic [FW-1:0] word,
  output fmt_kind_e     kind,
  output logic [CW-1:0] longs
);
  localparam int LW = FW / 2;

  logic [LW-1:0] code;
  logic [LW-1:0] size;

  assign code  = word[FW-1:LW];
  assign size  = word[LW-1:0];
  assign longs = size[LW-1:2];

  always_comb begin
    if (code == CODE_EMPTY)
      kind = FK_EMPTY;
    else if (code == CODE_RETRY)
      kind = FK_RETRY;
    else if (code < CODE_FIRST_VALID)
      kind = FK_BAD;
    else if (size[1:0] != 2'b00)
      kind = FK_BAD;
    else
      kind = FK_FRAME;
  end
endmodule

// File: rtl/cp_save_retry.sv
module cp_save_retry #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic expire
);
  localparam int RW = $clog2(LIMIT + 1);
  localparam logic [RW-1:0] LAST = RW'(LIMIT - 1);

  logic [RW-1:0] cnt;

  assign expire = bump && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (bump && !expire)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cp_save_frame_cnt.sv
module cp_save_frame_cnt #(
  parameter int AW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_longs,
  input  logic          adv,
  input  logic          consume,
  output logic [AW-1:0] offset,
  output logic          none_left,
  output logic          one_left
);
  logic [CW-1:0] remain;

  assign none_left = (remain == '0);
  assign one_left  = (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      offset <= '0;
    end else if (load) begin
      remain <= load_longs;
      offset <= '0;
    end else begin
      if (adv)
        offset <= offset + AW'(4);
      if (consume)
        remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/cp_save_seq.sv
module cp_save_seq
  import cp_save_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int FW          = 16,
  parameter int RETRY_LIMIT = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          done,
  output logic          format_error,
  output logic          timeout,
  output logic          cp_rd_valid,
  input  logic          cp_rd_ready,
  output logic          cp_rd_sel,
  input  logic [DW-1:0] cp_rd_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int CW = FW / 2 - 2;

  seq_state_e    state;
  logic [AW-1:0] base_q;
  logic [FW-1:0] fmt_q;
  logic [DW-1:0] opnd_q;
  logic          done_q, err_q, tmo_q;

  fmt_kind_e     kind;
  logic [CW-1:0] longs;
  logic [AW-1:0] offset;
  logic          none_left, one_left;
  logic          expire;

  logic rd_hs, wr_hs, take;
  logic fmt_hs, retry_hit, frame_load;

  assign rd_hs      = cp_rd_valid && cp_rd_ready;
  assign wr_hs      = mem_valid && mem_ready;
  assign take       = (state == ST_IDLE) && start;
  assign fmt_hs     = (state == ST_FMT_RD) && cp_rd_ready;
  assign retry_hit  = fmt_hs && (kind == FK_RETRY);
  assign frame_load = fmt_hs && ((kind == FK_EMPTY) || (kind == FK_FRAME));

  cp_save_fmt_decode #(.FW(FW), .CW(CW)) u_dec (
    .word  (cp_rd_data[FW-1:0]),
    .kind  (kind),
    .longs (longs)
  );

  cp_save_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (take),
    .bump   (retry_hit),
    .expire (expire)
  );

  cp_save_frame_cnt #(.AW(AW), .CW(CW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_load),
    .load_longs ((kind == FK_FRAME) ? longs : CW'(0)),
    .adv        (wr_hs),
    .consume    (wr_hs && (state == ST_OP_WR)),
    .offset     (offset),
    .none_left  (none_left),
    .one_left   (one_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      base_q <= '0;
      fmt_q  <= '0;
      opnd_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= base_addr;
            state  <= ST_FMT_RD;
          end
        end
        ST_FMT_RD: begin
          if (rd_hs) begin
            fmt_q <= cp_rd_data[FW-1:0];
            unique case (kind)
              FK_RETRY: begin
                if (expire) begin
                  tmo_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
                end
              end
              FK_BAD: begin
                err_q  <= 1'b1;
                done_q <= 1'b1;
                state  <= ST_IDLE;
              end
              default: state <= ST_FMT_WR;
            endcase
          end
        end
        ST_FMT_WR: begin
          if (wr_hs) begin
            if (none_left) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_OP_RD;
            end
          end
        end
        ST_OP_RD: begin
          if (rd_hs) begin
            opnd_q <= cp_rd_data;
            state  <= ST_OP_WR;
          end
        end
        ST_OP_WR: begin
          if (wr_hs) begin
            if (one_left) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_OP_RD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign format_error = err_q;
  assign timeout      = tmo_q;
  assign cp_rd_valid  = (state == ST_FMT_RD) || (state == ST_OP_RD);
  assign cp_rd_sel    = (state == ST_OP_RD);
  assign mem_valid    = (state == ST_FMT_WR) || (state == ST_OP_WR);
  assign mem_addr     = base_q + offset;
  assign mem_wdata    = (state == ST_FMT_WR) ? {{(DW-FW){1'b0}}, fmt_q} : opnd_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rd_valid && !cp_rd_ready |=> cp_rd_valid && $stable(cp_rd_sel));

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    format_error |-> done && !busy);

  // R4
  tmo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done && !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({format_error, timeout}));

  // R3
  no_wr_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_rd_valid && !cp_rd_sel |-> !mem_valid);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && cp_rd_valid && !cp_rd_sel);
endmodule

// File: tb/cp_save_seq_tb.sv
module cp_save_seq_tb;
  localparam int LIM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        busy, done, format_error, timeout;
  logic        cp_rd_valid, cp_rd_sel;
  logic        cp_rd_ready = 1'b0;
  logic [31:0] cp_rd_data = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;

  always #2 clk = ~clk;

  cp_save_seq #(.RETRY_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .format_error(format_error), .timeout(timeout),
    .cp_rd_valid(cp_rd_valid), .cp_rd_ready(cp_rd_ready), .cp_rd_sel(cp_rd_sel),
    .cp_rd_data(cp_rd_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // stimulus knobs
  logic [15:0] fmt_word = '0;
  int retries_left = 0;
  bit stall = 0;
  int op_idx = 0;
  int wr_cnt = 0;
  int done_cnt = 0;

  // behavioural reference
  int mph = 0;
  logic [31:0] mbase = '0;
  int mrem = 0, moff = 0, mretry = 0;
  logic [15:0] mfmt = '0;
  logic [31:0] mword = '0;
  bit e_done = 0, e_err = 0, e_to = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mph = 0; e_done = 0; e_err = 0; e_to = 0;
    end else begin
      e_done = 0; e_err = 0; e_to = 0;
      if (mph == 1 && cp_rd_ready && retries_left > 0) retries_left--;
      if (mph == 3 && cp_rd_ready) op_idx++;
      case (mph)
        0: if (start) begin mph = 1; mbase = base_addr; mretry = 0; end
        1: if (cp_rd_ready) begin
             int code, len;
             code = cp_rd_data[15:8];
             len  = cp_rd_data[7:0];
             mfmt = cp_rd_data[15:0];
             if (code == 1) begin
               mretry++;
               if (mretry == LIM) begin mph = 0; e_done = 1; e_to = 1; end
             end else if (code == 0) begin
               mrem = 0; moff = 0; mph = 2;
             end else if (code < 16 || (len % 4) != 0) begin
               mph = 0; e_done = 1; e_err = 1;
             end else begin
               mrem = len / 4; moff = 0; mph = 2;
             end
           end
        2: if (mem_ready) begin
             moff = 4;
             if (mrem == 0) begin mph = 0; e_done = 1; end else mph = 3;
           end
        3: if (cp_rd_ready) begin mword = cp_rd_data; mph = 4; end
        4: if (mem_ready) begin
             mrem--; moff += 4;
             if (mrem == 0) begin mph = 0; e_done = 1; end else mph = 3;
           end
        default: mph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (mph != 0), "R10", "busy", 32'(busy), 32'(mph != 0));
      chk(done == e_done, "R10", "done", 32'(done), 32'(e_done));
      chk(format_error == e_err, "R6", "format_error", 32'(format_error), 32'(e_err));
      chk(timeout == e_to, "R4", "timeout", 32'(timeout), 32'(e_to));
      chk(cp_rd_valid == (mph == 1 || mph == 3), "R2", "cp_rd_valid",
          32'(cp_rd_valid), 32'(mph == 1 || mph == 3));
      if (mph == 1 || mph == 3)
        chk(cp_rd_sel == (mph == 3), "R7", "cp_rd_sel", 32'(cp_rd_sel), 32'(mph == 3));
      chk(mem_valid == (mph == 2 || mph == 4), "R3", "mem_valid",
          32'(mem_valid), 32'(mph == 2 || mph == 4));
      if (mph == 2 || mph == 4) begin
        chk(mem_addr == mbase + 32'(moff), "R7", "mem_addr", mem_addr, mbase + 32'(moff));
        chk(mem_wdata == ((mph == 2) ? {16'h0, mfmt} : mword), "R5", "mem_wdata",
            mem_wdata, (mph == 2) ? {16'h0, mfmt} : mword);
      end
      if (done) done_cnt++;
    end
    cp_rd_ready = stall ? (($urandom % 3) != 0) : 1'b1;
    mem_ready   = stall ? (($urandom % 3) != 0) : 1'b1;
    if (cp_rd_sel) cp_rd_data = 32'hC0DE_0000 + 32'(op_idx);
    else if (retries_left > 0) cp_rd_data = 32'h5A5A_0100;
    else cp_rd_data = {16'hBEEF, fmt_word};
    if (mem_valid && mem_ready) wr_cnt++;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [15:0] f, input int nr, input bit stl,
                        input logic [31:0] base, input bit poke, input string req);
    int exp_w, w0, d0;
    fmt_word = f; retries_left = nr; stall = stl;
    if (nr >= LIM) exp_w = 0;
    else if (f[15:8] == 0) exp_w = 1;
    else if (f[15:8] < 16 || f[1:0] != 0) exp_w = 0;
    else exp_w = 1 + f[7:2];
    @(negedge clk);
    w0 = wr_cnt; d0 = done_cnt;
    base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = 32'hFFFF_0000;
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    chk(wr_cnt - w0 == exp_w, req, "write count", 32'(wr_cnt - w0), 32'(exp_w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !format_error && !timeout, "R1", "flags",
        {28'h0, busy, done, format_error, timeout}, 32'h0);
    chk(!cp_rd_valid && !mem_valid, "R1", "valids", {30'h0, cp_rd_valid, mem_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(16'h0000, 0, 0, 32'h0000_1000, 0, "R5");
    run_op(16'h1010, 0, 0, 32'h0000_2000, 0, "R7");
    run_op(16'h1000, 0, 0, 32'h0000_2100, 0, "R7");
    run_op(16'h2208, 2, 0, 32'h0000_3000, 0, "R3");
    run_op(16'h2208, LIM - 1, 0, 32'h0000_3100, 0, "R3");
    run_op(16'h1010, LIM, 0, 32'h0000_4000, 0, "R4");
    run_op(16'h0204, 0, 0, 32'h0000_5000, 0, "R6");
    run_op(16'h0700, 0, 0, 32'h0000_5100, 0, "R6");
    run_op(16'h0F10, 0, 0, 32'h0000_5200, 0, "R6");
    run_op(16'h1006, 0, 0, 32'h0000_6000, 0, "R8");
    run_op(16'hFF01, 0, 0, 32'h0000_6100, 0, "R8");
    run_op(16'h4020, 1, 1, 32'h0000_7000, 0, "R9");
    run_op(16'hFFFC, 0, 1, 32'h0000_8000, 0, "R9");
    run_op(16'h3010, 0, 0, 32'h0000_9000, 1, "R2");
    // R11 back-to-back: start held across done
    begin
      int d0, w0;
      fmt_word = 16'h1008; retries_left = 0; stall = 0;
      @(negedge clk);
      d0 = done_cnt; w0 = wr_cnt;
      base_addr = 32'h0000_A000; start = 1'b1;
      while (done_cnt < d0 + 2) @(negedge clk);
      start = 1'b0;
      chk(busy && cp_rd_valid && !cp_rd_sel, "R11", "restart after done",
          {29'h0, busy, cp_rd_valid, cp_rd_sel}, 32'h6);
      chk(wr_cnt - w0 == 6, "R11", "write count", 32'(wr_cnt - w0), 32'd6);
      while (done_cnt < d0 + 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule